// File: doc/BRIEF.md
# Multi-Cycle Instruction Step Sequencer

This block is the control sequencer of a small 32-bit load/store processor built around a shared bus. It steps through three fixed instruction-fetch steps. It then decodes the 5-bit opcode taken from the top of the instruction register. Last, it runs an execute sequence. In every step it drives one-hot strobes that move data through the datapath. These strobes cover register select, register read and write enables, operand and result latches, program counter and memory address controls, memory read, and an ALU operation select.

The supported instructions are a group of register-register ALU operations (add, subtract, and, or), a no-operation and a halt. A halt instruction stops the stepping and clears the run indicator. An external stop input does the same from any step. After that the sequencer stays frozen until the next asynchronous reset. While reset is held, the block drives a datapath clear strobe.

States and transitions: `ST_RST` → `ST_F0` → `ST_F1` → `ST_F2` → `ST_X3`. From `ST_X3`, an ALU opcode goes to `ST_X4` → `ST_X5` → `ST_F0`. A halt goes to `ST_HALT`. Any other opcode goes back to `ST_F0`. A stop seen at any clock edge moves to `ST_HALT`. `ST_HALT` holds until reset.

Top module: `step_sequencer`

## Requirements
- R1: While `rst` is high, `dp_clear` and `run` are 1 and every other strobe is 0. The first rising clock edge after release enters step T0.
- R2: In step T0 exactly `pc_drive`, `mar_ld`, `pc_inc` and `z_ld` are 1.
- R3: In step T1 exactly `zlo_drive`, `pc_ld`, `mem_rd` and `mdr_ld` are 1.
- R4: In step T2 exactly `mdr_drive` and `ir_ld` are 1. The strobes of steps T0 to T2 never depend on `opcode`.
- R5: The ALU opcodes are 5'b00011 add, 5'b00100 subtract, 5'b01001 and, 5'b01010 or. They select `alu_op` bit 0, 1, 2 and 3 respectively.
- R6: In step T3 of an ALU opcode exactly `sel_b`, `reg_rd` and `y_ld` are 1.
- R7: In step T4 exactly `sel_c`, `reg_rd`, `z_ld` and the `alu_op` bit of the opcode seen in T3 are 1. Later changes of `opcode` have no effect.
- R8: In step T5 exactly `zlo_drive`, `sel_a` and `reg_wr` are 1, and the next step is T0.
- R9: Opcode 5'b11010 (nop) and every opcode not listed in R5 or R10 give a T3 with no strobe asserted, followed by T0.
- R10: Opcode 5'b11011 (halt) gives a T3 with no strobe and `run` high. After that, `run` is 0 and all strobes are 0 until reset.
- R11: `stop` high at a rising clock edge in any step moves the sequencer to the halted condition of R10 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| stop | input | 1 | External stop request |
| opcode | input | 5 | Instruction register bits 31..27 |
| run | output | 1 | Run indicator |
| dp_clear | output | 1 | Clear all datapath registers |
| sel_a | output | 1 | Select destination register field |
| sel_b | output | 1 | Select first source register field |
| sel_c | output | 1 | Select second source register field |
| reg_wr | output | 1 | Write selected register from bus |
| reg_rd | output | 1 | Drive selected register onto bus |
| y_ld | output | 1 | Load operand latch Y |
| z_ld | output | 1 | Load result latch Z |
| pc_drive | output | 1 | Drive PC onto bus |
| pc_ld | output | 1 | Load PC from bus |
| pc_inc | output | 1 | ALU increments PC value |
| mar_ld | output | 1 | Load memory address register |
| mem_rd | output | 1 | Memory read |
| mdr_ld | output | 1 | Load memory data register |
| mdr_drive | output | 1 | Drive memory data register onto bus |
| ir_ld | output | 1 | Load instruction register |
| zlo_drive | output | 1 | Drive Z low word onto bus |
| alu_op | output | 4 | One-hot ALU select: add, sub, and, or |

## Verification
The bench builds the sequencer with its default parameters: a 5-bit opcode field and a four-entry ALU group. With these values every ALU select bit, the nop and halt codes and an unlisted code can all be driven. The bench puts junk opcodes on the input during the fetch steps and during T4 and T5. This shows that fetch ignores the opcode and that the ALU select is latched at T3. It raises stop in the middle of an instruction and also in the reset state, so the freeze can be observed from more than one step.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int OP_W  = 5;
    localparam int ALU_N = 4;

    localparam logic [OP_W-1:0] OPC_NOP  = 5'b11010;
    localparam logic [OP_W-1:0] OPC_HALT = 5'b11011;

    // index order = alu_op bit order: add, sub, and, or
    localparam logic [OP_W-1:0] ALU_CODES [ALU_N] = '{5'b00011, 5'b00100, 5'b01001, 5'b01010};

    typedef enum logic [2:0] {
        ST_RST, ST_F0, ST_F1, ST_F2, ST_X3, ST_X4, ST_X5, ST_HALT
    } step_t;

    typedef struct packed {
        logic clr;
        logic sel_a;
        logic sel_b;
        logic sel_c;
        logic reg_wr;
        logic reg_rd;
        logic y_ld;
        logic z_ld;
        logic pc_drive;
        logic pc_ld;
        logic pc_inc;
        logic mar_ld;
        logic mem_rd;
        logic mdr_ld;
        logic mdr_drive;
        logic ir_ld;
        logic zlo_drive;
    } strobe_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int W = OP_W,
    parameter int N = ALU_N
) (
    input  logic [W-1:0] opcode,
    output logic [N-1:0] alu_sel,
    output logic         is_alu,
    output logic         is_halt
);

    for (genvar i = 0; i < N; i++) begin : g_alu
        assign alu_sel[i] = (opcode == ALU_CODES[i]);
    end

    assign is_alu  = |alu_sel;
    assign is_halt = (opcode == OPC_HALT);

endmodule

// File: rtl/seq_outputs.sv
module seq_outputs
    import seq_pkg::*;
#(
    parameter int N = ALU_N
) (
    input  step_t          state,
    input  logic           alu_grp,
    input  logic [N-1:0]   alu_q,
    output strobe_t        stb,
    output logic [N-1:0]   alu_op,
    output logic           run
);

    always_comb begin
        stb    = '0;
        alu_op = '0;
        run    = 1'b1;
        unique case (state)
            ST_RST: stb.clr = 1'b1;
            ST_F0: begin
                stb.pc_drive = 1'b1;
                stb.mar_ld   = 1'b1;
                stb.pc_inc   = 1'b1;
                stb.z_ld     = 1'b1;
            end
            ST_F1: begin
                stb.zlo_drive = 1'b1;
                stb.pc_ld     = 1'b1;
                stb.mem_rd    = 1'b1;
                stb.mdr_ld    = 1'b1;
            end
            ST_F2: begin
                stb.mdr_drive = 1'b1;
                stb.ir_ld     = 1'b1;
            end
            ST_X3: begin
                if (alu_grp) begin
                    stb.sel_b  = 1'b1;
                    stb.reg_rd = 1'b1;
                    stb.y_ld   = 1'b1;
                end
            end
            ST_X4: begin
                stb.sel_c  = 1'b1;
                stb.reg_rd = 1'b1;
                stb.z_ld   = 1'b1;
                alu_op     = alu_q;
            end
            ST_X5: begin
                stb.zlo_drive = 1'b1;
                stb.sel_a     = 1'b1;
                stb.reg_wr    = 1'b1;
            end
            ST_HALT: run = 1'b0;
            default: run = 1'b0;
        endcase
    end

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import seq_pkg::*;
#(
    parameter int W = OP_W,
    parameter int N = ALU_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stop,
    input  logic [W-1:0] opcode,
    output logic         run,
    output logic         dp_clear,
    output logic         sel_a,
    output logic         sel_b,
    output logic         sel_c,
    output logic         reg_wr,
    output logic         reg_rd,
    output logic         y_ld,
    output logic         z_ld,
    output logic         pc_drive,
    output logic         pc_ld,
    output logic         pc_inc,
    output logic         mar_ld,
    output logic         mem_rd,
    output logic         mdr_ld,
    output logic         mdr_drive,
    output logic         ir_ld,
    output logic         zlo_drive,
    output logic [N-1:0] alu_op
);

    step_t        state, state_nx;
    logic [N-1:0] alu_sel, alu_q;
    logic         is_alu, is_halt;
    strobe_t      stb;

    seq_decode #(.W(W), .N(N)) u_dec (
        .opcode  (opcode),
        .alu_sel (alu_sel),
        .is_alu  (is_alu),
        .is_halt (is_halt)
    );

    // state register and opcode-select latch
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_RST;
            alu_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_X3) alu_q <= alu_sel;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RST:  state_nx = ST_F0;
            ST_F0:   state_nx = ST_F1;
            ST_F1:   state_nx = ST_F2;
            ST_F2:   state_nx = ST_X3;
            ST_X3: begin
                if (is_alu)       state_nx = ST_X4;
                else if (is_halt) state_nx = ST_HALT;
                else              state_nx = ST_F0;
            end
            ST_X4:   state_nx = ST_X5;
            ST_X5:   state_nx = ST_F0;
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_HALT;
        endcase
        if (stop) state_nx = ST_HALT;
    end

    seq_outputs #(.N(N)) u_out (
        .state   (state),
        .alu_grp (is_alu),
        .alu_q   (alu_q),
        .stb     (stb),
        .alu_op  (alu_op),
        .run     (run)
    );

    assign dp_clear  = stb.clr;
    assign sel_a     = stb.sel_a;
    assign sel_b     = stb.sel_b;
    assign sel_c     = stb.sel_c;
    assign reg_wr    = stb.reg_wr;
    assign reg_rd    = stb.reg_rd;
    assign y_ld      = stb.y_ld;
    assign z_ld      = stb.z_ld;
    assign pc_drive  = stb.pc_drive;
    assign pc_ld     = stb.pc_ld;
    assign pc_inc    = stb.pc_inc;
    assign mar_ld    = stb.mar_ld;
    assign mem_rd    = stb.mem_rd;
    assign mdr_ld    = stb.mdr_ld;
    assign mdr_drive = stb.mdr_drive;
    assign ir_ld     = stb.ir_ld;
    assign zlo_drive = stb.zlo_drive;

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         stop,
    input logic         run,
    input logic         sel_a,
    input logic         sel_b,
    input logic         sel_c,
    input logic         reg_wr,
    input logic         z_ld,
    input logic         mar_ld,
    input logic         mdr_ld,
    input logic         ir_ld,
    input logic [N-1:0] alu_op
);

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst) !run |=> !run);

    // R11
    stop_freeze_chk: assert property (@(posedge clk) disable iff (rst) stop |=> !run);

    // R3
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst) mar_ld |=> (mdr_ld || !run));

    // R4
    ir_after_mdr_chk: assert property (@(posedge clk) disable iff (rst) ir_ld |-> $past(mdr_ld));

    // R8
    wb_after_alu_chk: assert property (@(posedge clk) disable iff (rst) reg_wr |-> $past(z_ld));

    // R7
    alu_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(alu_op) && ((alu_op == '0) || (z_ld && sel_c)));

    // R6
    field_sel_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({sel_a, sel_b, sel_c}));

endmodule

bind step_sequencer seq_checker #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .stop   (stop),
    .run    (run),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .sel_c  (sel_c),
    .reg_wr (reg_wr),
    .z_ld   (z_ld),
    .mar_ld (mar_ld),
    .mdr_ld (mdr_ld),
    .ir_ld  (ir_ld),
    .alu_op (alu_op)
);

// File: tb/sim_step_sequencer.sv
module sim_step_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop = 1'b0;
    logic [4:0] opcode = 5'b10101;
    logic       run, dp_clear, sel_a, sel_b, sel_c, reg_wr, reg_rd, y_ld, z_ld;
    logic       pc_drive, pc_ld, pc_inc, mar_ld, mem_rd, mdr_ld, mdr_drive, ir_ld, zlo_drive;
    logic [3:0] alu_op;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    step_sequencer u0 (.*);

    // observed vector layout
    localparam logic [21:0] B_RUN = 22'd1 << 21, B_CLR = 22'd1 << 20, B_SA = 22'd1 << 19,
        B_SB = 22'd1 << 18, B_SC = 22'd1 << 17, B_RW = 22'd1 << 16, B_RR = 22'd1 << 15,
        B_Y = 22'd1 << 14, B_Z = 22'd1 << 13, B_PCD = 22'd1 << 12, B_PCL = 22'd1 << 11,
        B_PCI = 22'd1 << 10, B_MAR = 22'd1 << 9, B_RD = 22'd1 << 8, B_MDR = 22'd1 << 7,
        B_MDD = 22'd1 << 6, B_IR = 22'd1 << 5, B_ZLO = 22'd1 << 4;

    localparam logic [21:0] E_RST  = B_RUN | B_CLR;
    localparam logic [21:0] E_T0   = B_RUN | B_PCD | B_MAR | B_PCI | B_Z;
    localparam logic [21:0] E_T1   = B_RUN | B_ZLO | B_PCL | B_RD | B_MDR;
    localparam logic [21:0] E_T2   = B_RUN | B_MDD | B_IR;
    localparam logic [21:0] E_T3A  = B_RUN | B_SB | B_RR | B_Y;
    localparam logic [21:0] E_T5   = B_RUN | B_ZLO | B_SA | B_RW;
    localparam logic [21:0] E_IDLE = B_RUN;
    localparam logic [21:0] E_HALT = 22'd0;

    logic [21:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [21:0] observed();
        return {run, dp_clear, sel_a, sel_b, sel_c, reg_wr, reg_rd, y_ld, z_ld, pc_drive,
                pc_ld, pc_inc, mar_ld, mem_rd, mdr_ld, mdr_drive, ir_ld, zlo_drive, alu_op};
    endfunction

    // monitor: compare one expected item per cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [21:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (observed() !== e) begin
                mismatched++;
                $display("FAIL %s: actual %b expected %b", t, observed(), e);
            end
        end
    end

    task automatic step(input logic [4:0] op, input logic [21:0] e, input string t);
        @(negedge clk);
        opcode = op;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic fetch();
        step(5'b00011, E_T0, "R2 T0");
        step(5'b11011, E_T1, "R3 T1");
        step(5'b10111, E_T2, "R4 T2");
    endtask

    task automatic alu_instr(input logic [4:0] op, input logic [3:0] sel);
        fetch();
        step(op, E_T3A, "R6 T3");
        step(5'b11011, B_RUN | B_SC | B_RR | B_Z | {18'd0, sel}, "R5 R7 T4");
        step(5'b01001, E_T5, "R8 T5");
    endtask

    task automatic idle_instr(input logic [4:0] op);
        fetch();
        step(op, E_IDLE, "R9 T3 idle");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step(5'b00000, E_RST, "R1 reset");
        step(5'b00011, E_RST, "R1 reset held");
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        alu_instr(5'b00011, 4'b0001);
        alu_instr(5'b00100, 4'b0010);
        alu_instr(5'b01001, 4'b0100);
        alu_instr(5'b01010, 4'b1000);
        idle_instr(5'b11010);
        idle_instr(5'b11111);
        idle_instr(5'b00000);
        alu_instr(5'b00011, 4'b0001);   // R8 back at T0 after T5
        // R10 halt
        fetch();
        step(5'b11011, E_IDLE, "R10 T3 halt");
        for (int i = 0; i < 4; i++) step(5'b00011, E_HALT, "R10 halted");
        // R11 stop in mid-fetch
        do_reset();
        step(5'b00011, E_T0, "R2 T0");
        step(5'b00011, E_T1, "R11 T1 before stop");
        stop = 1'b1;
        step(5'b00011, E_HALT, "R11 stopped");
        stop = 1'b0;
        for (int i = 0; i < 3; i++) step(5'b00011, E_HALT, "R11 stays halted");
        // R11 stop while in reset state
        do_reset();
        stop = 1'b1;
        step(5'b00011, E_HALT, "R11 stop from reset");
        stop = 1'b0;
        step(5'b00011, E_HALT, "R11 stays halted");
        // R1 recovery
        do_reset();
        alu_instr(5'b01010, 4'b1000);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule